// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit with Guarded Accumulators

This block is the arithmetic core of a DSP datapath. It keeps a small bank of wide accumulators (two by default, each 40 bits: 32 data bits plus 8 guard bits). Each valid request names an operation, a destination accumulator, a second accumulator used as a source, and two 16-bit operands. The 16-bit operands act either as multiplier inputs or as the high and low halves of a 32-bit register pair. The operations are multiply, multiply-accumulate and multiply-subtract in signed-by-signed, signed-by-unsigned and unsigned-by-unsigned forms. There are also pair add and subtract, accumulator-to-accumulator add, negate, absolute value and shifts by an immediate count.

Two mode inputs shape every result. Fractional mode doubles each product. Saturation mode clamps results of the signed operations to the signed 32-bit range, while the accumulator itself stays 40 bits wide. Saturation without fractional mode is an illegal combination. It is reported on a one-cycle flag and leaves the accumulators untouched. Results are registered: a request accepted on one clock edge is visible on the accumulator outputs right after that edge, together with a one-cycle valid pulse.

Top module: `mac40_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every accumulator reads zero and out_valid and illegal are low.
- R2: A request with in_valid high at a clock edge updates the destination accumulator at that edge and pulses out_valid for one cycle. With in_valid low the accumulator outputs hold their value and out_valid stays low.
- R3: Accumulators are 40-bit two's complement and are sign-extended from bit 39 for every operation. Only the destination selected by dst_sel changes. With saturation off, results wrap modulo 2^40.
- R4: With frac_mode high, the product is shifted left by one and reinterpreted as a 40-bit signed value before use.
- R5: With sat_mode high, these operations clamp results above 0x7FFFFFFF to 0x7FFFFFFF and results below -0x80000000 to -0x80000000 (0xFF80000000): signed-by-signed multiply, multiply-accumulate and multiply-subtract, pair add and subtract, accumulator add, negate, absolute value and left shift.
- R6: For signed-by-signed multiply-accumulate and multiply-subtract with sat_mode high, a product above 0x7FFFFFFF is first clamped to 0x7FFFFFFF. It is then added or subtracted, and the result is clamped again per R5.
- R7: The signed-by-unsigned and unsigned-by-unsigned multiply, accumulate and subtract forms never saturate, even with sat_mode high; they wrap modulo 2^40. In the signed-by-unsigned forms, src_a is signed and src_b is unsigned.
- R8: The pair operand is src_a sign-extended as the upper 16 bits, concatenated with src_b as the lower 16 bits (a signed 32-bit value).
- R9: A request with sat_mode high and frac_mode low sets illegal for one cycle together with out_valid and changes no accumulator. Any other request leaves illegal low.
- R10: Shift operations take their count from src_b[3:0], and a count of 0 means 16. The right shift is arithmetic and never saturates. The left shift saturates under R5 and otherwise wraps.
- R11: Negate and absolute value of -0x80000000 give 0x7FFFFFFF with sat_mode high, and 0x0080000000 with it low.
- R12: op encoding (dst is the destination accumulator, src the accumulator named by src_sel): 0 mac s*s, 1 mac s*u, 2 mac u*u, 3 msub s*s, 4 msub s*u, 5 msub u*u, 6 mul s*s, 7 mul s*u, 8 mul u*u, 9 dst+pair, 10 dst-pair, 11 dst+src, 12 negate, 13 absolute, 14 arithmetic right shift, 15 left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code (R12) |
| dst_sel | input | SEL_W | Destination accumulator index |
| src_sel | input | SEL_W | Source accumulator index for accumulator add |
| src_a | input | DW | Multiplicand, or high half of the pair |
| src_b | input | DW | Multiplier, low half of the pair, or shift count |
| frac_mode | input | 1 | Double each product |
| sat_mode | input | 1 | Clamp signed results to the 32-bit range |
| acc_out | output | NACC*AW | All accumulators; accumulator i at bits [i*AW +: AW] |
| out_valid | output | 1 | Result pulse one cycle after a request |
| illegal | output | 1 | Saturation requested without fractional mode |

## Verification
The bench uses the default parameters: 16-bit operands, two 40-bit accumulators and a 32-bit saturation limit. With 16-bit operands, squaring 0x8000 in fractional mode lands exactly one above the 32-bit ceiling, which is the case that separates the product pre-clamp from the final clamp. The eight guard bits are few enough that a shift by 16 or repeated accumulator adds push values past bit 39, so wrapping is reachable. A seeded pseudo-random stream over all sixteen operations, both accumulators and all mode combinations follows the directed cases.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

  typedef enum logic [3:0] {
    OP_MAC_SS  = 4'd0,
    OP_MAC_SU  = 4'd1,
    OP_MAC_UU  = 4'd2,
    OP_MSB_SS  = 4'd3,
    OP_MSB_SU  = 4'd4,
    OP_MSB_UU  = 4'd5,
    OP_MUL_SS  = 4'd6,
    OP_MUL_SU  = 4'd7,
    OP_MUL_UU  = 4'd8,
    OP_ADD_PR  = 4'd9,
    OP_SUB_PR  = 4'd10,
    OP_ADD_ACC = 4'd11,
    OP_NEG     = 4'd12,
    OP_ABS     = 4'd13,
    OP_SRA     = 4'd14,
    OP_SLL     = 4'd15
  } mac_op_e;

  // Operations whose final result passes through the 32-bit clamp.
  function automatic logic op_saturates(mac_op_e o);
    case (o)
      OP_MAC_SS, OP_MSB_SS, OP_MUL_SS, OP_ADD_PR, OP_SUB_PR,
      OP_ADD_ACC, OP_NEG, OP_ABS, OP_SLL: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mac40_sat.sv
module mac40_sat #(
  parameter int W         = 58,
  parameter int AW        = 40,
  parameter int SAT_W     = 32,
  parameter bit CLAMP_LOW = 1'b1
) (
  input  logic signed [W-1:0] val,
  input  logic                en,
  output logic [AW-1:0]       res
);
  localparam logic signed [W-1:0] MAXV = (W'(1) << (SAT_W-1)) - W'(1);
  localparam logic signed [W-1:0] MINV = ~MAXV;

  logic over, under;
  assign over = en && (val > MAXV);

  generate
    if (CLAMP_LOW) begin : g_low
      assign under = en && (val < MINV);
    end else begin : g_nolow
      assign under = 1'b0;
    end
  endgenerate

  always_comb begin
    if (over)       res = MAXV[AW-1:0];
    else if (under) res = MINV[AW-1:0];
    else            res = val[AW-1:0];
  end
endmodule

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int DW = 16,
  parameter int AW = 40,
  parameter int SW = 58
) (
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic                 a_sgn,
  input  logic                 b_sgn,
  input  logic                 frac,
  output logic signed [SW-1:0] prod
);
  localparam int PW = 2*DW + 2;

  logic signed [DW:0]    a_e, b_e;
  logic signed [PW-1:0]  raw;
  logic signed [SW-1:0]  raw_x, dbl, dbl_t;

  assign a_e   = {a_sgn & a[DW-1], a};
  assign b_e   = {b_sgn & b[DW-1], b};
  assign raw   = a_e * b_e;
  assign raw_x = {{(SW-PW){raw[PW-1]}}, raw};
  assign dbl   = raw_x <<< 1;
  // re-interpret the doubled product at accumulator width
  assign dbl_t = {{(SW-AW){dbl[AW-1]}}, dbl[AW-1:0]};
  assign prod  = frac ? dbl_t : raw_x;
endmodule

// File: rtl/mac40_alu.sv
module mac40_alu
  import mac40_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int SAT_W = 32
) (
  input  logic [3:0]    op,
  input  logic [AW-1:0] acc_d,
  input  logic [AW-1:0] acc_s,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          frac,
  input  logic          sat,
  output logic [AW-1:0] nxt
);
  localparam int SW  = AW + DW + 2;
  localparam int SHW = $clog2(DW);

  mac_op_e opc;
  assign opc = mac_op_e'(op);

  logic a_sgn, b_sgn;
  assign a_sgn = opc inside {OP_MAC_SS, OP_MAC_SU, OP_MSB_SS, OP_MSB_SU, OP_MUL_SS, OP_MUL_SU};
  assign b_sgn = opc inside {OP_MAC_SS, OP_MSB_SS, OP_MUL_SS};

  logic signed [SW-1:0] d_x, s_x, pair_x, prod_x, prod_cx, wide;
  logic [AW-1:0]        prod_c;
  logic [SHW:0]         sh_amt;

  assign d_x    = {{(SW-AW){acc_d[AW-1]}}, acc_d};
  assign s_x    = {{(SW-AW){acc_s[AW-1]}}, acc_s};
  assign pair_x = {{(SW-2*DW){src_a[DW-1]}}, src_a, src_b};
  assign sh_amt = (src_b[SHW-1:0] == '0) ? (SHW+1)'(DW) : {1'b0, src_b[SHW-1:0]};

  mac40_mult #(.DW(DW), .AW(AW), .SW(SW)) u_mult (
    .a(src_a), .b(src_b), .a_sgn(a_sgn), .b_sgn(b_sgn), .frac(frac), .prod(prod_x)
  );

  // product pre-clamp: only the upper limit can be exceeded by a product
  mac40_sat #(.W(SW), .AW(AW), .SAT_W(SAT_W), .CLAMP_LOW(1'b0)) u_pre (
    .val(prod_x), .en(sat), .res(prod_c)
  );
  assign prod_cx = {{(SW-AW){prod_c[AW-1]}}, prod_c};

  always_comb begin
    case (opc)
      OP_MAC_SS:            wide = d_x + prod_cx;
      OP_MAC_SU, OP_MAC_UU: wide = d_x + prod_x;
      OP_MSB_SS:            wide = d_x - prod_cx;
      OP_MSB_SU, OP_MSB_UU: wide = d_x - prod_x;
      OP_MUL_SS, OP_MUL_SU,
      OP_MUL_UU:            wide = prod_x;
      OP_ADD_PR:            wide = d_x + pair_x;
      OP_SUB_PR:            wide = d_x - pair_x;
      OP_ADD_ACC:           wide = d_x + s_x;
      OP_NEG:               wide = -d_x;
      OP_ABS:               wide = d_x[SW-1] ? -d_x : d_x;
      OP_SRA:               wide = d_x >>> sh_amt;
      OP_SLL:               wide = d_x <<< sh_amt;
      default:              wide = d_x;
    endcase
  end

  mac40_sat #(.W(SW), .AW(AW), .SAT_W(SAT_W), .CLAMP_LOW(1'b1)) u_fin (
    .val(wide), .en(sat & op_saturates(opc)), .res(nxt)
  );
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int SAT_W = 32,
  parameter int NACC  = 2,
  localparam int SEL_W = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [3:0]           op,
  input  logic [SEL_W-1:0]     dst_sel,
  input  logic [SEL_W-1:0]     src_sel,
  input  logic [DW-1:0]        src_a,
  input  logic [DW-1:0]        src_b,
  input  logic                 frac_mode,
  input  logic                 sat_mode,
  output logic [NACC*AW-1:0]   acc_out,
  output logic                 out_valid,
  output logic                 illegal
);
  logic [AW-1:0] acc_q [NACC];
  logic [AW-1:0] acc_d, acc_s, nxt;
  logic          bad_mode, do_write;

  assign acc_d    = acc_q[dst_sel];
  assign acc_s    = acc_q[src_sel];
  assign bad_mode = sat_mode & ~frac_mode;
  assign do_write = in_valid & ~bad_mode;

  mac40_alu #(.DW(DW), .AW(AW), .SAT_W(SAT_W)) u_alu (
    .op(op), .acc_d(acc_d), .acc_s(acc_s), .src_a(src_a), .src_b(src_b),
    .frac(frac_mode), .sat(sat_mode), .nxt(nxt)
  );

  generate
    for (genvar i = 0; i < NACC; i++) begin : g_acc
      logic [AW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                 q <= '0;
        else if (do_write && dst_sel == SEL_W'(i)) q <= nxt;
      end
      assign acc_q[i]            = q;
      assign acc_out[i*AW +: AW] = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & bad_mode;
    end
  end
endmodule

// File: rtl/mac40_chk.sv
module mac40_chk
  import mac40_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int SAT_W = 32,
  parameter int NACC  = 2,
  parameter int SEL_W = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [3:0]         op,
  input logic [SEL_W-1:0]   dst_sel,
  input logic               frac_mode,
  input logic               sat_mode,
  input logic [NACC*AW-1:0] acc_out,
  input logic               out_valid,
  input logic               illegal
);
  logic             satop_q;
  logic [SEL_W-1:0] dst_q;
  logic [AW-1:0]    dst_val;
  logic             in_rng;

  always_ff @(posedge clk) begin
    if (rst) begin
      satop_q <= 1'b0;
      dst_q   <= '0;
    end else begin
      satop_q <= in_valid & sat_mode & frac_mode & op_saturates(mac_op_e'(op));
      dst_q   <= dst_sel;
    end
  end

  assign dst_val = acc_out[dst_q*AW +: AW];
  assign in_rng  = (&dst_val[AW-1:SAT_W-1]) | ~(|dst_val[AW-1:SAT_W-1]);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_out == '0 && !out_valid && !illegal));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(acc_out)));

  a_r9_illegal_blocks: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_mode && !frac_mode) |=> (illegal && $stable(acc_out)));

  a_r9_legal_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(sat_mode && !frac_mode)) |=> !illegal);

  a_r5_sat_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && satop_q) |-> in_rng);

  generate
    for (genvar i = 0; i < NACC; i++) begin : g_hold
      a_r3_other_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_sel != SEL_W'(i)) |=> $stable(acc_out[i*AW +: AW]));
    end
  endgenerate
endmodule

bind mac40_unit mac40_chk #(
  .DW(DW), .AW(AW), .SAT_W(SAT_W), .NACC(NACC), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .dst_sel(dst_sel),
  .frac_mode(frac_mode), .sat_mode(sat_mode), .acc_out(acc_out),
  .out_valid(out_valid), .illegal(illegal)
);

// File: tb/tb_mac40_unit.sv
`timescale 1ns/1ps
module tb_mac40_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [0:0]  dst_sel = '0, src_sel = '0;
  logic [15:0] src_a = '0, src_b = '0;
  logic        frac_mode = 1'b0, sat_mode = 1'b0;
  logic [79:0] acc_out;
  logic        out_valid, illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mac40_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .dst_sel(dst_sel),
    .src_sel(src_sel), .src_a(src_a), .src_b(src_b), .frac_mode(frac_mode),
    .sat_mode(sat_mode), .acc_out(acc_out), .out_valid(out_valid), .illegal(illegal)
  );

  localparam longint MAXS = 64'sh7FFF_FFFF;
  localparam longint MINS = -64'sh8000_0000;

  typedef struct {
    logic [79:0] acc;
    bit          ill;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [39:0] m_acc [2];

  function automatic longint sx(logic [39:0] v);
    longint r;
    r = {{24{v[39]}}, v};
    return r;
  endfunction

  function automatic logic [39:0] clampv(longint v, bit en);
    if (en && v > MAXS) return 40'h00_7FFF_FFFF;
    if (en && v < MINS) return 40'hFF_8000_0000;
    return v[39:0];
  endfunction

  function automatic longint product(int o, logic [15:0] a, logic [15:0] b, bit frac);
    bit sa, sb;
    longint pa, pb, p;
    sa = (o == 0 || o == 1 || o == 3 || o == 4 || o == 6 || o == 7);
    sb = (o == 0 || o == 3 || o == 6);
    pa = sa ? longint'($signed(a)) : longint'(a);
    pb = sb ? longint'($signed(b)) : longint'(b);
    p  = pa * pb;
    if (frac) p = sx(40'(p << 1));
    return p;
  endfunction

  function automatic logic [39:0] model(int o, logic [39:0] d, logic [39:0] s,
                                        logic [15:0] a, logic [15:0] b, bit frac, bit sat);
    longint dv, sv, p, pc, pr;
    int sh;
    dv = sx(d);
    sv = sx(s);
    p  = product(o, a, b, frac);
    pc = (sat && p > MAXS) ? MAXS : p;
    pr = longint'($signed({a, b}));
    sh = (b[3:0] == 4'd0) ? 16 : int'(b[3:0]);
    case (o)
      0:       return clampv(dv + pc, sat);
      1, 2:    return clampv(dv + p, 1'b0);
      3:       return clampv(dv - pc, sat);
      4, 5:    return clampv(dv - p, 1'b0);
      6:       return clampv(p, sat);
      7, 8:    return clampv(p, 1'b0);
      9:       return clampv(dv + pr, sat);
      10:      return clampv(dv - pr, sat);
      11:      return clampv(dv + sv, sat);
      12:      return clampv(-dv, sat);
      13:      return clampv((dv < 0) ? -dv : dv, sat);
      14:      return clampv(dv >>> sh, 1'b0);
      default: return clampv(dv <<< sh, sat);
    endcase
  endfunction

  // driver: one request per call, expectation pushed to the scoreboard
  task automatic run_op(int o, int d, int s, logic [15:0] a, logic [15:0] b,
                        bit frac, bit sat, string tag);
    item_t it;
    @(negedge clk);
    op = 4'(o); dst_sel = 1'(d); src_sel = 1'(s);
    src_a = a; src_b = b; frac_mode = frac; sat_mode = sat; in_valid = 1'b1;
    it.ill = sat && !frac;
    if (!it.ill) m_acc[d] = model(o, m_acc[d], m_acc[s], a, b, frac, sat);
    it.acc = {m_acc[1], m_acc[0]};
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = src_a + 16'h1357;
      op = op + 4'd1;
    end
  endtask

  // monitor: compares every result pulse against the queue head
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2: out_valid=1 expected 0 (no request pending)");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (acc_out !== it.acc || illegal !== it.ill) begin
          bad++;
          $display("FAIL %s: acc_out=%h illegal=%0b expected acc_out=%h illegal=%0b",
                   it.tag, acc_out, illegal, it.acc, it.ill);
        end
      end
    end
  end

  task automatic direct_check(string tag, logic [79:0] acc_e, bit v_e, bit ill_e);
    total++;
    if (acc_out !== acc_e || out_valid !== v_e || illegal !== ill_e) begin
      bad++;
      $display("FAIL %s: acc_out=%h out_valid=%0b illegal=%0b expected %h %0b %0b",
               tag, acc_out, out_valid, illegal, acc_e, v_e, ill_e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] x;
    m_acc[0] = '0; m_acc[1] = '0;
    repeat (3) @(negedge clk);
    direct_check("R1 during reset", 80'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    direct_check("R1 after reset", 80'h0, 1'b0, 1'b0);

    run_op(6, 0, 0, 16'd3,    16'hFFFC, 0, 0, "R12 mul s*s");
    run_op(0, 0, 0, 16'h0100, 16'h0200, 0, 0, "R12 mac s*s");
    run_op(6, 1, 0, 16'd3,    16'd5,    1, 0, "R4 frac doubles");
    run_op(1, 1, 0, 16'hFFFF, 16'hFFFF, 0, 0, "R7 mac s*u");
    run_op(8, 0, 0, 16'hFFFF, 16'hFFFF, 0, 0, "R7 mul u*u");
    run_op(15, 0, 0, 16'h0,   16'h0,    0, 0, "R10 sll count0 wraps R3");
    run_op(14, 0, 0, 16'h0,   16'h0,    0, 0, "R10 sra count0");
    run_op(14, 0, 0, 16'h0,   16'h4,    0, 0, "R10 sra by 4");
    run_op(6, 1, 0, 16'h0,    16'h0,    0, 0, "R12 clear");
    run_op(9, 1, 0, 16'h8000, 16'h0000, 0, 0, "R8 pair min");
    run_op(12, 1, 0, 16'h0,   16'h0,    1, 1, "R11 neg min sat");
    run_op(6, 1, 0, 16'h0,    16'h0,    0, 0, "R12 clear");
    run_op(9, 1, 0, 16'h8000, 16'h0000, 0, 0, "R8 pair min");
    run_op(13, 1, 0, 16'h0,   16'h0,    1, 1, "R11 abs min sat");
    run_op(9, 1, 0, 16'hFFFF, 16'h0001, 0, 0, "R8 pair negative");
    run_op(6, 1, 0, 16'h0,    16'h0,    0, 0, "R12 clear");
    run_op(9, 1, 0, 16'h8000, 16'h0000, 0, 0, "R8 pair min");
    run_op(13, 1, 0, 16'h0,   16'h0,    0, 0, "R11 abs min nosat");
    run_op(6, 0, 0, 16'hFFFF, 16'd5,    0, 0, "R12 load -5");
    run_op(0, 0, 0, 16'h8000, 16'h8000, 1, 1, "R6 mac preclamp");
    run_op(6, 1, 0, 16'h0,    16'h0,    0, 0, "R12 clear");
    run_op(3, 1, 0, 16'h8000, 16'h8000, 1, 1, "R6 msub preclamp");
    run_op(6, 0, 0, 16'h8000, 16'h8000, 1, 1, "R5 mul clamp");
    run_op(9, 0, 0, 16'h7FFF, 16'hFFFF, 1, 1, "R5 pair add clamp");
    run_op(10, 1, 0, 16'h7FFF, 16'hFFFF, 1, 1, "R5 pair sub clamp");
    run_op(11, 1, 1, 16'h0,   16'h0,    1, 1, "R5 acc add clamp");
    run_op(2, 0, 0, 16'hFFFF, 16'hFFFF, 1, 1, "R7 mac u*u no sat");
    run_op(5, 0, 0, 16'h0001, 16'hFFFF, 1, 1, "R7 msub u*u no sat");
    run_op(4, 1, 0, 16'h8000, 16'hFFFF, 1, 1, "R7 msub s*u no sat");
    run_op(0, 0, 0, 16'h1234, 16'h5678, 0, 1, "R9 illegal mode");
    run_op(7, 1, 0, 16'h8000, 16'hFFFF, 1, 0, "R12 mul s*u");
    run_op(15, 1, 0, 16'h0,   16'h3,    1, 1, "R10 sll sat");
    run_op(8, 0, 0, 16'hFFFF, 16'hFFFF, 0, 0, "R12 mul u*u");
    run_op(15, 0, 0, 16'h0,   16'h7,    0, 0, "R10 sll by 7");
    run_op(11, 0, 0, 16'h0,   16'h0,    0, 0, "R3 acc add wrap");
    run_op(11, 0, 0, 16'h0,   16'h0,    0, 0, "R3 acc add wrap");
    run_op(11, 1, 0, 16'h0,   16'h0,    0, 0, "R3 cross acc add");
    idle(4);
    total++;
    if (exp_q.size() != 0 || acc_out !== {m_acc[1], m_acc[0]}) begin
      bad++;
      $display("FAIL R2: idle acc_out=%h pending=%0d expected %h pending=0",
               acc_out, exp_q.size(), {m_acc[1], m_acc[0]});
    end

    x = 32'h1BADF00D;
    for (int n = 0; n < 200; n++) begin
      bit fr, st;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      fr = x[6];
      st = x[7] & (x[8] | fr);
      run_op(int'(x[3:0]), int'(x[4]), int'(x[5]), x[31:16], x[24:9], fr, st,
             "R3 mixed stream");
      if (x[10] && x[11]) idle(1);
    end
    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2: pending=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule